// File: doc/BRIEF.md
# Burst Power-Up Switch Sequencer

This block is the digital controller for a dual-band transmit power control loop that is switched on only for the slots in which it transmits. While the power-up input is low it keeps every analog switch open. Both driver stages stay disabled and both control outputs are pulled to ground. When power-up rises, the block captures the band choice for the whole burst. It then steps the analog switches through a fixed order: sampling of the detector offset, pre-bias of the control output, a wait for the DAC ramp, a kick onto the home voltage, and hand-over to the closed loop.

All internal waits are counted in clock cycles and set by parameters. An elaboration-time check rejects a kick delay that would exceed the 3 µs budget at the stated clock frequency. A ramp-detected strobe from an external comparator moves the sequence from pre-bias to home. Strobes that arrive while sampling is still under way are ignored, so sampling cannot be cut short. A falling power-up input returns everything to the safe idle pattern on the next clock edge, whatever phase the sequence has reached.

Top module: `burst_switch_seq`

## Requirements
- R1: In reset, and whenever power-up was low at the previous clock edge, all five switch controls and both feedback lines are low (open), both `drv_en` bits are 0 and both `out_gnd` bits are 1; ramp strobes and band changes during idle leave this pattern unchanged.
- R2: At the first clock edge that samples `pwr_up` high in idle, the block samples `band_sel` (0 selects band index 0, 1 selects band index 1). It then closes `sw_sample`, `sw_prebias` and the selected `fb_sw` bit, with `sw_home` and `sw_loop` open.
- R3: Throughout a burst, the selected band has `drv_en`=1 and `out_gnd`=0. The other band has its `fb_sw` bit at 0, `drv_en` at 0 and `out_gnd` at 1.
- R4: `sw_sample` stays closed for exactly `S1_HOLD_CYC` cycles and then opens. Pre-bias and feedback stay closed while the block waits for a ramp.
- R5: A `ramp_det` strobe sampled while `sw_sample` is closed is ignored: the block still opens `sw_sample` on schedule and then waits for a fresh strobe with `sw_home` open.
- R6: A `ramp_det` strobe sampled after `sw_sample` has opened opens `sw_prebias` and closes `sw_home` exactly `KICK_DLY_CYC` cycles after the sampling edge. `KICK_DLY_CYC` must not exceed 3 µs at `CLK_MHZ`.
- R7: After `sw_home` closes, the selected feedback switch stays closed for exactly `PRESET_CYC` cycles. Then it opens and `sw_loop` closes. `sw_home` stays closed, and this closed-loop pattern holds until power-up falls.
- R8: Changes on `band_sel` while power-up stays high have no effect on any output; a new band is taken only at the next rising power-up.
- R9: From any phase, the first clock edge that samples `pwr_up` low returns all outputs to the idle pattern of R1. This takes one clock period, well inside 1 µs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_up | input | 1 | Burst enable, high for the transmitted slot |
| band_sel | input | BSEL_W | Band choice, sampled at power-up rise |
| ramp_det | input | 1 | Ramp-detected strobe from external comparator |
| sw_sample | output | 1 | Detector offset sampling switch, 1 = closed |
| sw_prebias | output | 1 | Pre-bias forcing switch, 1 = closed |
| sw_home | output | 1 | Home-voltage switch, 1 = closed |
| sw_loop | output | 1 | Loop-close switch, 1 = closed |
| fb_sw | output | N_BANDS | Per-band integrator feedback switch, 1 = closed |
| drv_en | output | N_BANDS | Per-band output driver enable |
| out_gnd | output | N_BANDS | Per-band control output force-to-ground |

## Verification
On every cycle, the embedded properties check several safety rules. The unused band is never enabled, and pre-bias and home are never closed together. The loop switch and the feedback switches are never closed at once. A falling power-up always leaves the drivers off one edge later, and the band register never moves outside a power-up rise. The exact phase lengths can only be shown by the bench's burst scenarios, which measure how many cycles each switch stays in each state. The same holds for ignoring an early ramp, keeping the band fixed within a burst, and aborting from the middle of the sequence.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SAMPLE = 3'd1,
    ST_READY  = 3'd2,
    ST_KICK   = 3'd3,
    ST_PRESET = 3'd4,
    ST_LOOP   = 3'd5
  } bsq_state_e;

endpackage

// File: rtl/bsq_timer.sv
module bsq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

  // R4 R6 R7: the counter parks at zero and never wraps
  p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero);

endmodule

// File: rtl/bsq_band_latch.sv
module bsq_band_latch #(
  parameter int N_BANDS = 2,
  parameter int BSEL_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [BSEL_W-1:0] band_sel,
  output logic [N_BANDS-1:0] band_oh
);

  logic [BSEL_W-1:0] band_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      band_q <= '0;
    end else if (capture) begin
      band_q <= band_sel;
    end
  end

  for (genvar gi = 0; gi < N_BANDS; gi++) begin : g_dec
    assign band_oh[gi] = (band_q == BSEL_W'(gi));
  end

  // R8: band register moves only on a capture strobe
  p_band_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(band_q));

  p_band_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(band_oh));

endmodule

// File: rtl/bsq_sw_decode.sv
module bsq_sw_decode
  import bsq_pkg::*;
#(
  parameter int N_BANDS = 2
) (
  input  bsq_state_e         state,
  input  logic [N_BANDS-1:0] band_oh,
  output logic               sw_sample,
  output logic               sw_prebias,
  output logic               sw_home,
  output logic               sw_loop,
  output logic [N_BANDS-1:0] fb_sw,
  output logic [N_BANDS-1:0] drv_en,
  output logic [N_BANDS-1:0] out_gnd
);

  logic active;
  logic fb_phase;

  always_comb begin
    active     = (state != ST_IDLE);
    sw_sample  = (state == ST_SAMPLE);
    sw_prebias = (state == ST_SAMPLE) || (state == ST_READY) || (state == ST_KICK);
    sw_home    = (state == ST_PRESET) || (state == ST_LOOP);
    sw_loop    = (state == ST_LOOP);
    fb_phase   = active && (state != ST_LOOP);
  end

  for (genvar gb = 0; gb < N_BANDS; gb++) begin : g_band
    assign fb_sw[gb]   = fb_phase && band_oh[gb];
    assign drv_en[gb]  = active && band_oh[gb];
    assign out_gnd[gb] = !(active && band_oh[gb]);
  end

endmodule

// File: rtl/burst_switch_seq.sv
module burst_switch_seq
  import bsq_pkg::*;
#(
  parameter int N_BANDS      = 2,
  parameter int CLK_MHZ      = 125,
  parameter int S1_HOLD_CYC  = 40,
  parameter int KICK_DLY_CYC = 6,
  parameter int PRESET_CYC   = 250,
  localparam int BSEL_W      = (N_BANDS > 1) ? $clog2(N_BANDS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwr_up,
  input  logic [BSEL_W-1:0]  band_sel,
  input  logic               ramp_det,
  output logic               sw_sample,
  output logic               sw_prebias,
  output logic               sw_home,
  output logic               sw_loop,
  output logic [N_BANDS-1:0] fb_sw,
  output logic [N_BANDS-1:0] drv_en,
  output logic [N_BANDS-1:0] out_gnd
);

  localparam int MAX_A   = (S1_HOLD_CYC > KICK_DLY_CYC) ? S1_HOLD_CYC : KICK_DLY_CYC;
  localparam int MAX_CYC = (MAX_A > PRESET_CYC) ? MAX_A : PRESET_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int KICK_LIMIT_CYC = 3 * CLK_MHZ;

  if (KICK_DLY_CYC < 1 || KICK_DLY_CYC > KICK_LIMIT_CYC) begin : g_kick_bad
    $error("kick delay outside 1..3us window");
  end
  if (S1_HOLD_CYC < 1 || PRESET_CYC < 1) begin : g_hold_bad
    $error("hold intervals must be at least one cycle");
  end

  bsq_state_e       state_q;
  bsq_state_e       state_d;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_zero;
  logic             band_cap;
  logic [N_BANDS-1:0] band_oh;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    band_cap = 1'b0;
    if (state_q != ST_IDLE && !pwr_up) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (pwr_up) begin
            state_d  = ST_SAMPLE;
            band_cap = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(S1_HOLD_CYC - 1);
          end
        end
        ST_SAMPLE: begin
          if (tmr_zero) state_d = ST_READY;
        end
        ST_READY: begin
          if (ramp_det) begin
            state_d  = ST_KICK;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(KICK_DLY_CYC - 1);
          end
        end
        ST_KICK: begin
          if (tmr_zero) begin
            state_d  = ST_PRESET;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(PRESET_CYC - 1);
          end
        end
        ST_PRESET: begin
          if (tmr_zero) state_d = ST_LOOP;
        end
        ST_LOOP: state_d = ST_LOOP;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  bsq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  bsq_band_latch #(.N_BANDS(N_BANDS), .BSEL_W(BSEL_W)) u_band (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (band_cap),
    .band_sel (band_sel),
    .band_oh  (band_oh)
  );

  bsq_sw_decode #(.N_BANDS(N_BANDS)) u_dec (
    .state      (state_q),
    .band_oh    (band_oh),
    .sw_sample  (sw_sample),
    .sw_prebias (sw_prebias),
    .sw_home    (sw_home),
    .sw_loop    (sw_loop),
    .fb_sw      (fb_sw),
    .drv_en     (drv_en),
    .out_gnd    (out_gnd)
  );

  // R1: one edge after power-up was low, everything is safe
  p_idle_safe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pwr_up) |-> (!sw_sample && !sw_prebias && !sw_home && !sw_loop &&
                         fb_sw == '0 && drv_en == '0 && out_gnd == '1));

  // R2: a rising power-up starts with sampling and pre-bias closed
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pwr_up) && state_q == ST_IDLE) |=>
      (sw_sample && sw_prebias && !sw_home && !sw_loop));

  // R3: at most one driver, and feedback only on the enabled band
  p_one_driver_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drv_en));
  for (genvar ga = 0; ga < N_BANDS; ga++) begin : g_fb_chk
    p_fb_on_driven_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fb_sw[ga] |-> (drv_en[ga] && !out_gnd[ga]));
  end

  // R5: sampling phase never leads straight to home
  p_sample_no_kick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sw_sample |=> !sw_home);

  // R6: pre-bias and home are never closed together
  p_prebias_home_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_prebias && sw_home));

  // R7: loop closed means feedback switches are open
  p_loop_fb_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sw_loop |-> (fb_sw == '0 && sw_home));

  // R9: a falling power-up leaves drivers off on the next edge
  p_shutdown_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_up) |=> (drv_en == '0 && !sw_loop));

endmodule

// File: tb/burst_switch_seq_tb.sv
module burst_switch_seq_tb;

  localparam int CLKMHZ = 125;
  localparam int S1C    = 40;
  localparam int KC     = 6;
  localparam int PC     = 250;

  logic       clk;
  logic       rst_n;
  logic       pwr_up;
  logic [0:0] band_sel;
  logic       ramp_det;
  logic       sw_sample, sw_prebias, sw_home, sw_loop;
  logic [1:0] fb_sw, drv_en, out_gnd;

  int checks;
  int errors;

  burst_switch_seq #(
    .N_BANDS(2), .CLK_MHZ(CLKMHZ), .S1_HOLD_CYC(S1C),
    .KICK_DLY_CYC(KC), .PRESET_CYC(PC)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_up(pwr_up), .band_sel(band_sel),
    .ramp_det(ramp_det), .sw_sample(sw_sample), .sw_prebias(sw_prebias),
    .sw_home(sw_home), .sw_loop(sw_loop), .fb_sw(fb_sw),
    .drv_en(drv_en), .out_gnd(out_gnd)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // phase: 0 idle, 1 sampling, 2 waiting/kick, 3 preset, 4 loop
  function automatic logic [9:0] exp_out(int ph, logic b);
    logic [1:0] sel, fb, drv;
    sel = b ? 2'b10 : 2'b01;
    fb  = (ph >= 1 && ph <= 3) ? sel : 2'b00;
    drv = (ph != 0) ? sel : 2'b00;
    return {ph == 1, ph == 1 || ph == 2, ph >= 3, ph == 4, fb, drv, ~drv};
  endfunction

  function automatic logic [9:0] obs();
    return {sw_sample, sw_prebias, sw_home, sw_loop, fb_sw, drv_en, out_gnd};
  endfunction

  task automatic chk_vec(string tag, logic [9:0] act, logic [9:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, expv);
    end
  endtask

  task automatic chk_int(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // abort: 0 none, 1 after sampling, 2 during preset, 3 right after start
  task automatic run_burst(logic b, bit early, bit toggle, int abort);
    int n;
    @(negedge clk);
    band_sel = b;
    pwr_up   = 1'b1;
    @(negedge clk);
    chk_vec("R2,R3 start pattern", obs(), exp_out(1, b));
    if (toggle) band_sel = ~b;
    if (abort == 3) begin
      pwr_up = 1'b0;
      @(negedge clk);
      chk_vec("R9 abort in sampling", obs(), exp_out(0, b));
      return;
    end
    n = 0;
    while (sw_sample === 1'b1 && n < 5000) begin
      n++;
      ramp_det = early && (n == 3);
      @(negedge clk);
    end
    ramp_det = 1'b0;
    chk_int("R4 sampling length", n, S1C);
    chk_vec("R5,R8 waiting pattern", obs(), exp_out(2, b));
    if (abort == 1) begin
      pwr_up = 1'b0;
      @(negedge clk);
      chk_vec("R9 abort while waiting", obs(), exp_out(0, b));
      return;
    end
    repeat ($urandom_range(1, 20)) @(negedge clk);
    chk_vec("R5 still waiting", obs(), exp_out(2, b));
    ramp_det = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      ramp_det = 1'b0;
      n++;
    end while (sw_home !== 1'b1 && n < 5000);
    chk_int("R6 kick delay", n, KC + 1);
    chk_int("R6 kick within 3us", ((n - 1) * 1000 <= 3000 * CLKMHZ) ? 1 : 0, 1);
    chk_vec("R7 preset pattern", obs(), exp_out(3, b));
    if (abort == 2) begin
      repeat (5) @(negedge clk);
      pwr_up = 1'b0;
      @(negedge clk);
      chk_vec("R9 abort in preset", obs(), exp_out(0, b));
      return;
    end
    n = 0;
    while (sw_home === 1'b1 && sw_loop !== 1'b1 && n < 5000) begin
      n++;
      @(negedge clk);
    end
    chk_int("R7 preset length", n, PC);
    chk_vec("R7 loop pattern", obs(), exp_out(4, b));
    band_sel = ~band_sel;
    ramp_det = 1'b1;
    repeat ($urandom_range(2, 30)) @(negedge clk);
    ramp_det = 1'b0;
    chk_vec("R7,R8 loop hold", obs(), exp_out(4, b));
    pwr_up = 1'b0;
    @(negedge clk);
    chk_vec("R9 end of burst", obs(), exp_out(0, b));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed_dummy;
    checks   = 0;
    errors   = 0;
    seed_dummy = $urandom(32'd1357);
    rst_n    = 1'b0;
    pwr_up   = 1'b0;
    band_sel = 1'b0;
    ramp_det = 1'b0;
    repeat (3) @(negedge clk);
    chk_vec("R1 in reset", obs(), exp_out(0, 1'b0));
    rst_n = 1'b1;
    @(negedge clk);
    chk_vec("R1 after reset", obs(), exp_out(0, 1'b0));
    ramp_det = 1'b1;
    band_sel = 1'b1;
    repeat (4) @(negedge clk);
    ramp_det = 1'b0;
    chk_vec("R1 idle ignores inputs", obs(), exp_out(0, 1'b0));

    run_burst(1'b0, 1'b0, 1'b0, 0);
    run_burst(1'b1, 1'b0, 1'b0, 0);
    run_burst(1'b0, 1'b1, 1'b1, 0);
    run_burst(1'b1, 1'b1, 1'b0, 1);
    run_burst(1'b0, 1'b0, 1'b1, 2);
    run_burst(1'b1, 1'b0, 1'b0, 3);

    for (int i = 0; i < 16; i++) begin
      logic rb;
      bit   re, rt;
      int   ra;
      rb = 1'($urandom_range(0, 1));
      re = 1'($urandom_range(0, 1));
      rt = 1'($urandom_range(0, 1));
      ra = ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 3)) : 0;
      repeat ($urandom_range(1, 8)) @(negedge clk);
      run_burst(rb, re, rt, ra);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule